// File: doc/BRIEF.md
# Counter Access Gating Unit

This block is the register-side front end for the cycle and retired-instruction counters of a processor core. It decodes a counter-related register address, decides whether code at the current privilege level may read a user-visible counter, and returns the read value or flags the access as illegal. Two 32-bit enable registers set the policy. One is owned by machine mode and gates both supervisor and user reads. The other is owned by supervisor mode and additionally gates user reads.

The cycle and retired-instruction views share one 64-bit count, which advances on a retire pulse. When the core runs in narrow (32-bit) mode, the count is read and written as two halves, and each half-write merges into the other half. The performance-counter slots that are not built read as zero, so software can probe them safely. Reads are combinational from the current state. Writes take effect at the next rising clock edge.

Top module: `ctr_gate`

## Requirements
- R1: Privilege is encoded as user=0, supervisor=1, machine=3. The value 2 counts as below machine but not below supervisor. A read at machine level is always permitted. Below machine, bit `csr_addr[4:0]` of the machine enable register must be 1. Below supervisor, the same bit of the supervisor enable register must also be 1.
- R2: A read of a user-visible counter address is illegal when it is not permitted. User-visible addresses are 0xC00 and 0xC02–0xC1F, plus 0xC80 and 0xC82–0xC9F in narrow mode. An illegal read sets `illegal` to 1 and drives `rd_data` to zero.
- R3: A permitted read of a user performance counter returns zero. These are 0xC03–0xC1F, plus 0xC83–0xC9F in narrow mode.
- R4: Reads of the machine performance counters (0xB03–0xB1F) return zero at every privilege level. The same holds for their high halves (0xB83–0xB9F) in narrow mode and for the event selectors (0x323–0x33F).
- R5: The cycle addresses (0xC00, 0xB00) and the retired-instruction addresses (0xC02, 0xB02) read the same count. In wide mode the read returns all 64 bits. In narrow mode it returns bits 31:0, zero-extended.
- R6: In narrow mode, the high-half addresses 0xC80, 0xC82, 0xB80 and 0xB82 return bits 63:32 of the count. In wide mode, every address in 0xC80–0xC9F and 0xB80–0xB9F is illegal.
- R7: A write to 0xB00 or 0xB02 replaces only bits 31:0 of the count in narrow mode. In wide mode it replaces all 64 bits.
- R8: In narrow mode, a write to 0xB80 or 0xB82 replaces bits 63:32 with `wr_data[31:0]` and keeps bits 31:0. In wide mode such a write is ignored.
- R9: The count increases by one on every clock edge where `retire` is 1. A count write in the same cycle takes precedence over the increment.
- R10: The machine enable register (0x306) and the supervisor enable register (0x106) are 32 bits wide and fully writable. Both read back zero-extended. Both enable registers and the count reset to zero.
- R11: Any address outside the decoded set reads as illegal; this includes 0xC01, 0xB01 and 0x300. Writes to such addresses, and to the read-only user-visible addresses, change no state.
- R12: When `rd_en` is 0, `illegal` is 0 and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | Register address of the access |
| priv | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| narrow_mode | input | 1 | 1 selects 32-bit split-half behaviour |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| retire | input | 1 | Count-advance pulse |
| rd_data | output | 64 | Read value |
| illegal | output | 1 | Read is not allowed or address is unknown |

## Verification
The hardest situation to reach is a narrow-mode half write that interacts with a carry between the two halves of the count. To get there, the stimulus first loads a wide-mode value just below the 32-bit boundary. It then keeps retiring in narrow mode, so the carry moves into the upper half, and only after that writes each half separately. Same-cycle collisions between a write and a retire pulse are placed on purpose, not left to chance. A long mixed phase then sweeps privilege, mode and both enable masks against a behavioural model.

// File: rtl/ctr_gate_pkg.sv
package ctr_gate_pkg;

    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPV  = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [3:0] {
        CK_NONE,
        CK_UCNT,
        CK_UCNT_HI,
        CK_UHPM,
        CK_UHPM_HI,
        CK_MCNT,
        CK_MCNT_HI,
        CK_MHPM,
        CK_MHPM_HI,
        CK_MEVT,
        CK_MEN,
        CK_SEN
    } csr_kind_e;

    typedef struct packed {
        csr_kind_e  kind;
        logic [4:0] idx;
    } csr_class_t;

    // Address groups of 32 registers, selected by addr[11:5]
    localparam logic [6:0] GRP_USER_LO = 7'h60;  // 0xC00
    localparam logic [6:0] GRP_USER_HI = 7'h64;  // 0xC80
    localparam logic [6:0] GRP_MACH_LO = 7'h58;  // 0xB00
    localparam logic [6:0] GRP_MACH_HI = 7'h5C;  // 0xB80
    localparam logic [6:0] GRP_EVENT   = 7'h19;  // 0x320
    localparam logic [ADDR_W-1:0] ADDR_MEN = 12'h306;
    localparam logic [ADDR_W-1:0] ADDR_SEN = 12'h106;

    function automatic csr_kind_e pick(input logic [4:0] idx,
                                       input csr_kind_e cnt_k,
                                       input csr_kind_e hpm_k);
        if (idx == 5'd0 || idx == 5'd2) return cnt_k;
        if (idx >= 5'd3)                return hpm_k;
        return CK_NONE;
    endfunction

    function automatic csr_class_t classify(input logic [ADDR_W-1:0] a);
        csr_class_t c;
        c.idx = a[4:0];
        unique case (a[11:5])
            GRP_USER_LO: c.kind = pick(a[4:0], CK_UCNT, CK_UHPM);
            GRP_USER_HI: c.kind = pick(a[4:0], CK_UCNT_HI, CK_UHPM_HI);
            GRP_MACH_LO: c.kind = pick(a[4:0], CK_MCNT, CK_MHPM);
            GRP_MACH_HI: c.kind = pick(a[4:0], CK_MCNT_HI, CK_MHPM_HI);
            GRP_EVENT:   c.kind = (a[4:0] >= 5'd3) ? CK_MEVT : CK_NONE;
            default: begin
                if (a == ADDR_MEN)      c.kind = CK_MEN;
                else if (a == ADDR_SEN) c.kind = CK_SEN;
                else                    c.kind = CK_NONE;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ctr_gate_decode.sv
module ctr_gate_decode
    import ctr_gate_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output csr_class_t        cls
);
    always_comb cls = classify(addr);
endmodule

// File: rtl/ctr_gate_permit.sv
module ctr_gate_permit
    import ctr_gate_pkg::*;
#(
    parameter int EN_W = 32,
    localparam int IDX_W = $clog2(EN_W)
) (
    input  priv_e            priv,
    input  logic [EN_W-1:0]  mach_en,
    input  logic [EN_W-1:0]  supv_en,
    input  logic [IDX_W-1:0] idx,
    output logic             permit
);
    logic [EN_W-1:0] mask;
    logic            below_mach;
    logic            below_supv;

    assign below_mach = (priv != PRIV_MACH);
    assign below_supv = (priv == PRIV_USER);

    for (genvar i = 0; i < EN_W; i++) begin : g_bit
        assign mask[i] = (below_mach ? mach_en[i] : 1'b1)
                       & (below_supv ? supv_en[i] : 1'b1);
    end

    assign permit = mask[idx];
endmodule

// File: rtl/ctr_gate_enables.sv
module ctr_gate_enables #(
    parameter int EN_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_mach,
    input  logic            wr_supv,
    input  logic [EN_W-1:0] wdata,
    output logic [EN_W-1:0] mach_en,
    output logic [EN_W-1:0] supv_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mach_en <= '0;
            supv_en <= '0;
        end else begin
            if (wr_mach) mach_en <= wdata;
            if (wr_supv) supv_en <= wdata;
        end
    end

    assert_mach_en_write_R10: assert property (@(posedge clk) disable iff (rst)
        wr_mach |=> mach_en == $past(wdata));
    assert_supv_en_write_R10: assert property (@(posedge clk) disable iff (rst)
        wr_supv |=> supv_en == $past(wdata));
    assert_en_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!wr_mach && !wr_supv) |=> ($stable(mach_en) && $stable(supv_en)));
endmodule

// File: rtl/ctr_gate_count.sv
module ctr_gate_count #(
    parameter int CNT_W = 64,
    localparam int HALF_W = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             split,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [CNT_W-1:0] wdata,
    input  logic             retire,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (wr_lo) begin
            if (split) count <= {count[CNT_W-1:HALF_W], wdata[HALF_W-1:0]};
            else       count <= wdata;
        end else if (wr_hi) begin
            count <= {wdata[HALF_W-1:0], count[HALF_W-1:0]};
        end else if (retire) begin
            count <= count + 1'b1;
        end
    end

    assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
        (retire && !wr_lo && !wr_hi) |=> count == $past(count) + 1'b1);
    assert_count_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!retire && !wr_lo && !wr_hi) |=> $stable(count));
    assert_lo_keeps_hi_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && split) |=> count[CNT_W-1:HALF_W] == $past(count[CNT_W-1:HALF_W]));
    assert_hi_keeps_lo_R8: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> count[HALF_W-1:0] == $past(count[HALF_W-1:0]));
endmodule

// File: rtl/ctr_gate.sv
module ctr_gate
    import ctr_gate_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int EN_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [1:0]        priv,
    input  logic              narrow_mode,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              retire,
    output logic [CNT_W-1:0]  rd_data,
    output logic              illegal
);
    localparam int HALF_W = CNT_W / 2;
    localparam int IDX_W  = $clog2(EN_W);

    csr_class_t       cls;
    priv_e            priv_q;
    logic             permit;
    logic [EN_W-1:0]  mach_en;
    logic [EN_W-1:0]  supv_en;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] lo_view;
    logic [CNT_W-1:0] hi_view;
    logic [CNT_W-1:0] value;
    logic             bad;
    logic             wr_lo;
    logic             wr_hi;

    assign priv_q = priv_e'(priv);

    ctr_gate_decode u_decode (
        .addr (csr_addr),
        .cls  (cls)
    );

    ctr_gate_permit #(.EN_W(EN_W)) u_permit (
        .priv    (priv_q),
        .mach_en (mach_en),
        .supv_en (supv_en),
        .idx     (cls.idx[IDX_W-1:0]),
        .permit  (permit)
    );

    ctr_gate_enables #(.EN_W(EN_W)) u_enables (
        .clk     (clk),
        .rst     (rst),
        .wr_mach (wr_en && cls.kind == CK_MEN),
        .wr_supv (wr_en && cls.kind == CK_SEN),
        .wdata   (wr_data[EN_W-1:0]),
        .mach_en (mach_en),
        .supv_en (supv_en)
    );

    assign wr_lo = wr_en && (cls.kind == CK_MCNT);
    assign wr_hi = wr_en && narrow_mode && (cls.kind == CK_MCNT_HI);

    ctr_gate_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst    (rst),
        .split  (narrow_mode),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .wdata  (wr_data),
        .retire (retire),
        .count  (count)
    );

    assign lo_view = narrow_mode ? {{HALF_W{1'b0}}, count[HALF_W-1:0]} : count;
    assign hi_view = {{HALF_W{1'b0}}, count[CNT_W-1:HALF_W]};

    always_comb begin
        bad   = 1'b0;
        value = '0;
        unique case (cls.kind)
            CK_UCNT:    if (permit) value = lo_view; else bad = 1'b1;
            CK_UCNT_HI: if (permit && narrow_mode) value = hi_view; else bad = 1'b1;
            CK_UHPM:    bad = !permit;
            CK_UHPM_HI: bad = !(permit && narrow_mode);
            CK_MCNT:    value = lo_view;
            CK_MCNT_HI: if (narrow_mode) value = hi_view; else bad = 1'b1;
            CK_MHPM:    value = '0;
            CK_MHPM_HI: bad = !narrow_mode;
            CK_MEVT:    value = '0;
            CK_MEN:     value = CNT_W'(mach_en);
            CK_SEN:     value = CNT_W'(supv_en);
            default:    bad = 1'b1;
        endcase
    end

    assign illegal = rd_en && bad;
    assign rd_data = (rd_en && !bad) ? value : '0;

    assert_illegal_needs_read_R12: assert property (@(posedge clk) disable iff (rst)
        illegal |-> rd_en);
    assert_illegal_zero_data_R2: assert property (@(posedge clk) disable iff (rst)
        illegal |-> rd_data == '0);
    assert_machine_permitted_R1: assert property (@(posedge clk) disable iff (rst)
        (priv_q == PRIV_MACH) |-> permit);
    assert_event_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && cls.kind == CK_MEVT) |-> (rd_data == '0 && !illegal));
    assert_wide_high_illegal_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !narrow_mode && (cls.kind == CK_MCNT_HI || cls.kind == CK_UCNT_HI))
        |-> illegal);
endmodule

// File: tb/ctr_gate_tb_top.sv
module ctr_gate_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] csr_addr = '0;
    logic [1:0]  priv = 2'd3;
    logic        narrow_mode = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        retire = 1'b0;
    logic [63:0] rd_data;
    logic        illegal;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string focus = "R10";

    bit [63:0] m_cnt = '0;
    bit [31:0] m_men = '0;
    bit [31:0] m_sen = '0;

    always #10 clk = ~clk;

    ctr_gate dut_i (
        .clk (clk), .rst (rst), .csr_addr (csr_addr), .priv (priv),
        .narrow_mode (narrow_mode), .rd_en (rd_en), .wr_en (wr_en),
        .wr_data (wr_data), .retire (retire), .rd_data (rd_data),
        .illegal (illegal)
    );

    task automatic model_read(input int a, input int p, input bit r32, input bit en,
                              output bit [63:0] d, output bit ill, output string tag);
        int  lo;
        bit  ok;
        bit  is_cnt;
        lo = a % 32;
        ok = 1'b1;
        if (p != 3) ok = ok && m_men[lo];
        if (p == 0) ok = ok && m_sen[lo];
        is_cnt = (lo == 0 || lo == 2);
        d = '0; ill = 1'b0; tag = "R11";
        if (a >= 'hC00 && a <= 'hC1F) begin
            if (lo == 1) ill = 1'b1;
            else if (!ok) begin ill = 1'b1; tag = "R2"; end
            else if (is_cnt) begin tag = "R5"; d = r32 ? {32'h0, m_cnt[31:0]} : m_cnt; end
            else tag = "R3";
        end else if (a >= 'hC80 && a <= 'hC9F) begin
            if (lo == 1) ill = 1'b1;
            else if (!r32) begin ill = 1'b1; tag = "R6"; end
            else if (!ok) begin ill = 1'b1; tag = "R2"; end
            else if (is_cnt) begin tag = "R6"; d = {32'h0, m_cnt[63:32]}; end
            else tag = "R3";
        end else if (a >= 'hB00 && a <= 'hB1F) begin
            if (lo == 1) ill = 1'b1;
            else if (is_cnt) begin tag = "R5"; d = r32 ? {32'h0, m_cnt[31:0]} : m_cnt; end
            else tag = "R4";
        end else if (a >= 'hB80 && a <= 'hB9F) begin
            if (lo == 1) ill = 1'b1;
            else if (!r32) begin ill = 1'b1; tag = "R6"; end
            else if (is_cnt) begin tag = "R6"; d = {32'h0, m_cnt[63:32]}; end
            else tag = "R4";
        end else if (a >= 'h323 && a <= 'h33F) begin
            tag = "R4";
        end else if (a == 'h306) begin
            tag = "R10"; d = {32'h0, m_men};
        end else if (a == 'h106) begin
            tag = "R10"; d = {32'h0, m_sen};
        end else begin
            ill = 1'b1;
        end
        if (!en) begin d = '0; ill = 1'b0; tag = "R12"; end
    endtask

    task automatic model_step(input int a, input bit r32, input bit wr,
                              input bit [63:0] wd, input bit ret);
        if (rst) begin
            m_cnt = '0; m_men = '0; m_sen = '0;
        end else begin
            if (wr && a == 'h306) m_men = wd[31:0];
            if (wr && a == 'h106) m_sen = wd[31:0];
            if (wr && (a == 'hB00 || a == 'hB02))
                m_cnt = r32 ? {m_cnt[63:32], wd[31:0]} : wd;
            else if (wr && r32 && (a == 'hB80 || a == 'hB82))
                m_cnt = {wd[31:0], m_cnt[31:0]};
            else if (ret)
                m_cnt = m_cnt + 64'd1;
        end
    endtask

    task automatic cyc(input int a, input int p, input bit r32, input bit rd,
                       input bit wr, input bit [63:0] wd, input bit ret);
        bit [63:0] ed;
        bit        ei;
        string     tag;
        @(negedge clk);
        csr_addr = a[11:0]; priv = p[1:0]; narrow_mode = r32;
        rd_en = rd; wr_en = wr; wr_data = wd; retire = ret;
        #2;
        model_read(a, p, r32, rd, ed, ei, tag);
        n_cmp++;
        if (rd_data !== ed || illegal !== ei) begin
            n_bad++;
            $display("FAIL %s/%s addr=%h priv=%0d narrow=%0b: got data=%h ill=%b, expected data=%h ill=%b",
                     focus, tag, a, p, r32, rd_data, illegal, ed, ei);
        end
        @(posedge clk);
        model_step(a, r32, wr, wd, ret);
    endtask

    task automatic rd(input int a, input int p, input bit r32);
        cyc(a, p, r32, 1'b1, 1'b0, 64'h0, 1'b0);
    endtask

    task automatic wr(input int a, input bit r32, input bit [63:0] wd, input bit ret);
        cyc(a, 3, r32, 1'b0, 1'b1, wd, ret);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        // R10: reset state while reset is held
        focus = "R10";
        rd('hB00, 3, 1'b0);
        rst = 1'b0;
        rd('h306, 3, 1'b0);
        rd('h106, 3, 1'b0);
        rd('hB02, 3, 1'b0);

        // R9: retire pulses advance the count
        focus = "R9";
        for (int i = 0; i < 5; i++) cyc('hB00, 3, 1'b0, 1'b1, 1'b0, 64'h0, 1'b1);
        rd('hB00, 3, 1'b0);
        rd('hB02, 3, 1'b0);

        // R1/R2: privilege gating through both enable registers
        focus = "R1";
        rd('hC00, 0, 1'b0);
        rd('hC00, 1, 1'b0);
        rd('hC00, 3, 1'b0);
        wr('h306, 1'b0, 64'h1, 1'b0);
        rd('hC00, 1, 1'b0);
        rd('hC00, 0, 1'b0);
        wr('h106, 1'b0, 64'h1, 1'b0);
        rd('hC00, 0, 1'b0);
        focus = "R2";
        rd('hC02, 0, 1'b0);
        rd('hC02, 1, 1'b0);
        wr('h306, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        rd('h306, 3, 1'b0);
        rd('hC02, 1, 1'b0);
        rd('hC02, 0, 1'b0);
        rd('hC02, 2, 1'b0);

        // R3: user performance counters
        focus = "R3";
        rd('hC05, 0, 1'b0);
        wr('h106, 1'b0, 64'hFFFF_FFFF, 1'b0);
        rd('hC05, 0, 1'b0);
        rd('hC1F, 0, 1'b0);
        rd('hC85, 0, 1'b1);

        // R4: machine counters and event selectors
        focus = "R4";
        rd('hB05, 0, 1'b0);
        rd('hB1F, 1, 1'b0);
        rd('h323, 0, 1'b0);
        rd('h33F, 3, 1'b0);
        rd('hB85, 3, 1'b1);
        rd('hB85, 3, 1'b0);

        // R7: carry across the half boundary, then narrow low write
        focus = "R7";
        wr('hB00, 1'b0, 64'h0000_0005_FFFF_FFFE, 1'b0);
        for (int i = 0; i < 4; i++) cyc('hB80, 3, 1'b1, 1'b1, 1'b0, 64'h0, 1'b1);
        rd('hB00, 3, 1'b1);
        wr('hB02, 1'b1, 64'hAAAA_BBBB_0000_0011, 1'b1);
        rd('hB80, 3, 1'b1);
        rd('hB00, 3, 1'b1);
        rd('hB00, 3, 1'b0);

        // R8: narrow high write, wide high write ignored
        focus = "R8";
        wr('hB82, 1'b1, 64'h1234_5678_CAFE_0001, 1'b0);
        rd('hB82, 3, 1'b1);
        rd('hB02, 3, 1'b1);
        wr('hB80, 1'b0, 64'h0000_0000_DEAD_0000, 1'b1);
        rd('hB00, 3, 1'b0);

        // R6: high halves by mode
        focus = "R6";
        rd('hC80, 0, 1'b1);
        rd('hC82, 1, 1'b1);
        rd('hC80, 0, 1'b0);
        rd('hB82, 3, 1'b0);

        // R5: both views, both modes
        focus = "R5";
        rd('hC00, 0, 1'b0);
        rd('hC02, 0, 1'b0);
        rd('hC02, 0, 1'b1);

        // R9: write collides with retire
        focus = "R9";
        wr('hB00, 1'b0, 64'h0000_0000_0000_0100, 1'b1);
        rd('hB00, 3, 1'b0);

        // R11: unknown addresses and read-only targets
        focus = "R11";
        rd('hC01, 3, 1'b0);
        rd('hB01, 3, 1'b0);
        rd('h300, 3, 1'b0);
        wr('hC00, 1'b0, 64'h7777, 1'b0);
        wr('h300, 1'b0, 64'h7777, 1'b0);
        rd('hB00, 3, 1'b0);

        // R12: no read strobe
        focus = "R12";
        cyc('h300, 0, 1'b0, 1'b0, 1'b0, 64'h0, 1'b0);
        cyc('hB00, 3, 1'b0, 1'b0, 1'b0, 64'h0, 1'b1);

        // Mixed sweep
        focus = "R1";
        for (int i = 0; i < 3000; i++) begin
            int pool [14] = '{'hC00, 'hC02, 'hC07, 'hC80, 'hC82, 'hC9E, 'hB00,
                              'hB02, 'hB80, 'hB82, 'h306, 'h106, 'h325, 'hC01};
            int a;
            bit w;
            bit [63:0] d;
            a = pool[$urandom_range(13)];
            w = ($urandom_range(5) == 0);
            d = {$urandom, $urandom};
            cyc(a, $urandom_range(3), $urandom_range(1), !w, w, d, $urandom_range(1));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no finish, expected finish within limit");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule